// File: doc/BRIEF.md
# Video and OSD Overlay Mixer

This block merges two pixel streams, one from a video layer and one from an on-screen-display (OSD) layer, into a single 24-bit RGB output pixel. The OSD layer only counts inside a rectangular window that software programs. Outside that window, or while the OSD is switched off, the video pixel passes through unchanged.

Inside the window, the OSD pixel is tested against a colour key. A per-bit mask selects which bits take part in the test. One programmable action applies when the key matches and another when it does not. Each action picks the video pixel, the OSD pixel, or a weighted blend of the two.

An optional blink function hides the OSD layer for alternating stretches of frames. The length of each stretch is counted in vertical sync pulses. The output is registered, so every result appears one clock after its inputs.

Top module: `osd_overlay_mixer`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `mix_pix` is 0. Reset also leaves the OSD in its shown state and the blink counter at zero.
- R2: `mix_pix` is registered with one cycle of latency. When the pixel lies outside the window, or `osd_en` is 0, it equals the `vid_pix` of the previous cycle.
- R3: `win_start` holds the 1-based first column in bits [15:0] and the 1-based first row in bits [31:16]. `win_end` holds the last column and last row, inclusive, in the same layout. A pixel at 0-based (x, y) is inside the window when start.x <= x+1 <= end.x and start.y <= y+1 <= end.y.
- R4: The key and the mask are each packed as R in [23:16], G in [15:8] and B in [7:0]. With `key_en` = 1, a pixel matches when `osd_pix` equals `key_color` in every bit position where `key_mask` is 1; bits where the mask is 0 are ignored.
- R5: With `key_en` = 0, every pixel inside the window takes the no-match action, even when `osd_pix` equals the key.
- R6: `ovl_ctrl[1:0]` is the no-match action and `ovl_ctrl[3:2]` the match action. Each action is encoded 0 = video, 1 = OSD, 2 = blend; the value 3 selects video.
- R7: The blend action outputs, per 8-bit channel, floor((video*W + osd*(15-W))/15), where W = `ovl_ctrl[7:4]`. So W = 15 gives the video pixel and W = 0 gives the OSD pixel.
- R8: With `blink_en` = 1, each `vsync` pulse advances a counter. When the count reaches the period in `ovl_ctrl[23:16]`, the counter restarts and the OSD toggles between shown and hidden; a period of 0 acts as 1. A hidden OSD gives the video pixel. A pixel presented in the same cycle as the toggling pulse still sees the old state.
- R9: With `blink_en` = 0, the OSD is shown and the counter is held at zero. Re-enabling blinking therefore starts a full period with the OSD shown.
- R10: `vsync` pulses have no effect on the output while `blink_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_pix | input | 24 | Video layer pixel, RGB 8:8:8 |
| osd_pix | input | 24 | OSD layer pixel, RGB 8:8:8 |
| pix_x | input | 16 | 0-based column of the current pixel |
| pix_y | input | 16 | 0-based row of the current pixel |
| vsync | input | 1 | One-cycle vertical sync strobe |
| osd_en | input | 1 | OSD layer enable |
| key_en | input | 1 | Colour key comparison enable |
| blink_en | input | 1 | Blink enable |
| ovl_ctrl | input | 32 | Actions [3:0], blend weight [7:4], blink period [23:16] |
| key_color | input | 24 | Colour key |
| key_mask | input | 24 | Comparison mask, 1 = bit compared |
| win_start | input | 32 | Window start, row [31:16], column [15:0], 1-based |
| win_end | input | 32 | Window end, row [31:16], column [15:0], inclusive |
| mix_pix | output | 24 | Mixed output pixel |

## Verification
The hardest situation to reach is the blink toggle. It needs a run of `vsync` pulses to bring the counter up to the period, and a pixel must land in exactly the cycle of the toggling pulse to show that the old state still applies there. The bench drives `vsync` pulses back to back with a pixel on each one. It follows the counter and the shown/hidden state in its own model, so the pixels on either side of each toggle are predicted. The periods 0 and 3 are both used, and blinking is disabled partway through a count to show that the next enable starts from zero.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    // Overlay control field positions
    localparam int NOMATCH_LSB = 0;
    localparam int MATCH_LSB   = 2;
    localparam int WEIGHT_LSB  = 4;
    localparam int PERIOD_LSB  = 16;

    typedef enum logic [1:0] {
        ACT_VIDEO = 2'd0,
        ACT_OSD   = 2'd1,
        ACT_BLEND = 2'd2,
        ACT_RSVD  = 2'd3
    } ovl_act_e;
endpackage

// File: rtl/ovl_window.sv
module ovl_window #(
    parameter int COORD_W = 16
) (
    input  logic [COORD_W-1:0]   pix_x,
    input  logic [COORD_W-1:0]   pix_y,
    input  logic [2*COORD_W-1:0] win_start,
    input  logic [2*COORD_W-1:0] win_end,
    output logic                 in_win
);
    localparam int EXT_W = COORD_W + 1;

    logic [EXT_W-1:0] x1, y1, xs, ys, xe, ye;

    always_comb begin
        x1 = EXT_W'(pix_x) + EXT_W'(1);
        y1 = EXT_W'(pix_y) + EXT_W'(1);
        xs = EXT_W'(win_start[COORD_W-1:0]);
        ys = EXT_W'(win_start[2*COORD_W-1:COORD_W]);
        xe = EXT_W'(win_end[COORD_W-1:0]);
        ye = EXT_W'(win_end[2*COORD_W-1:COORD_W]);
        in_win = (x1 >= xs) && (x1 <= xe) && (y1 >= ys) && (y1 <= ye);
    end

    // R3: an empty (inverted) column range never yields an inside pixel
    always_comb begin
        if (xs > xe) a_r3_empty_window: assert (!in_win);
    end
endmodule

// File: rtl/ovl_key_match.sv
module ovl_key_match #(
    parameter int PIX_W = 24
) (
    input  logic             key_en,
    input  logic [PIX_W-1:0] osd_pix,
    input  logic [PIX_W-1:0] key_color,
    input  logic [PIX_W-1:0] key_mask,
    output logic             match
);
    logic [PIX_W-1:0] diff;

    always_comb begin
        diff  = (osd_pix ^ key_color) & key_mask;
        match = key_en && (diff == '0);
    end

    // R4: an all-zero mask makes every OSD pixel a match
    // R5: no match is reported while keying is off
    always_comb begin
        if (key_en && key_mask == '0) a_r4_zero_mask_matches: assert (match);
        if (!key_en) a_r5_key_off_no_match: assert (!match);
    end
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend #(
    parameter int CH_W     = 8,
    parameter int CHANNELS = 3,
    parameter int WEIGHT_W = 4
) (
    input  logic [CH_W*CHANNELS-1:0] vid_pix,
    input  logic [CH_W*CHANNELS-1:0] osd_pix,
    input  logic [WEIGHT_W-1:0]      weight,
    output logic [CH_W*CHANNELS-1:0] mix_pix
);
    localparam int NW = CH_W + WEIGHT_W;
    localparam logic [WEIGHT_W-1:0] WMAX = '1;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        logic [CH_W-1:0] v, o;
        logic [NW-1:0]   pv, po, num;

        always_comb begin
            v   = vid_pix[c*CH_W +: CH_W];
            o   = osd_pix[c*CH_W +: CH_W];
            pv  = NW'(v) * NW'(weight);
            po  = NW'(o) * NW'(WMAX - weight);
            num = pv + po;
            mix_pix[c*CH_W +: CH_W] = CH_W'(num / NW'(WMAX));
        end
    end

    // R7: full weight returns the video pixel, zero weight the OSD pixel
    always_comb begin
        if (weight == WMAX) a_r7_full_weight_video: assert (mix_pix == vid_pix);
        if (weight == '0)   a_r7_zero_weight_osd:   assert (mix_pix == osd_pix);
    end
endmodule

// File: rtl/ovl_blink.sv
module ovl_blink #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vsync,
    input  logic                blink_en,
    input  logic [PERIOD_W-1:0] period,
    output logic                hidden
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic                hid;
    } blink_st_t;

    blink_st_t st_d, st_q;
    logic [PERIOD_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        if (!blink_en) begin
            st_d.cnt = '0;
            st_d.hid = 1'b0;
        end else if (vsync) begin
            if (cnt_inc >= {1'b0, period}) begin
                st_d.cnt = '0;
                st_d.hid = ~st_q.hid;
            end else begin
                st_d.cnt = cnt_inc[PERIOD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hidden = st_q.hid;

    // R8: the shown/hidden state moves only on a vsync pulse
    a_r8_toggle_on_vsync_only: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && !vsync) |=> $stable(hidden));
    // R9: disabling blinking shows the OSD and clears the count
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |=> (!hidden && st_q.cnt == '0));
endmodule

// File: rtl/osd_overlay_mixer.sv
module osd_overlay_mixer
    import ovl_pkg::*;
#(
    parameter int CH_W     = 8,
    parameter int COORD_W  = 16,
    parameter int WEIGHT_W = 4,
    parameter int PERIOD_W = 8,
    parameter int CTRL_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3*CH_W-1:0]     vid_pix,
    input  logic [3*CH_W-1:0]     osd_pix,
    input  logic [COORD_W-1:0]    pix_x,
    input  logic [COORD_W-1:0]    pix_y,
    input  logic                  vsync,
    input  logic                  osd_en,
    input  logic                  key_en,
    input  logic                  blink_en,
    input  logic [CTRL_W-1:0]     ovl_ctrl,
    input  logic [3*CH_W-1:0]     key_color,
    input  logic [3*CH_W-1:0]     key_mask,
    input  logic [2*COORD_W-1:0]  win_start,
    input  logic [2*COORD_W-1:0]  win_end,
    output logic [3*CH_W-1:0]     mix_pix
);
    localparam int PIX_W = 3 * CH_W;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } mix_st_t;

    mix_st_t st_d, st_q;

    logic                in_win, match, hidden, osd_vis;
    logic [PIX_W-1:0]    blend_pix;
    logic [WEIGHT_W-1:0] weight;
    logic [PERIOD_W-1:0] period;
    ovl_act_e            act_match, act_nomatch, act;
    logic                ctrl_unused;

    assign weight      = ovl_ctrl[WEIGHT_LSB +: WEIGHT_W];
    assign period      = ovl_ctrl[PERIOD_LSB +: PERIOD_W];
    assign act_match   = ovl_act_e'(ovl_ctrl[MATCH_LSB +: 2]);
    assign act_nomatch = ovl_act_e'(ovl_ctrl[NOMATCH_LSB +: 2]);
    assign ctrl_unused = ^{ovl_ctrl[PERIOD_LSB-1:WEIGHT_LSB+WEIGHT_W],
                           ovl_ctrl[CTRL_W-1:PERIOD_LSB+PERIOD_W]};

    ovl_window #(.COORD_W(COORD_W)) u_window (
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .win_start (win_start),
        .win_end   (win_end),
        .in_win    (in_win)
    );

    ovl_key_match #(.PIX_W(PIX_W)) u_key (
        .key_en    (key_en),
        .osd_pix   (osd_pix),
        .key_color (key_color),
        .key_mask  (key_mask),
        .match     (match)
    );

    ovl_blend #(.CH_W(CH_W), .CHANNELS(3), .WEIGHT_W(WEIGHT_W)) u_blend (
        .vid_pix (vid_pix),
        .osd_pix (osd_pix),
        .weight  (weight),
        .mix_pix (blend_pix)
    );

    ovl_blink #(.PERIOD_W(PERIOD_W)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync    (vsync),
        .blink_en (blink_en),
        .period   (period),
        .hidden   (hidden)
    );

    always_comb begin
        st_d    = st_q;
        osd_vis = osd_en && in_win && !hidden;
        act     = match ? act_match : act_nomatch;
        if (!osd_vis) begin
            st_d.pix = vid_pix;
        end else begin
            unique case (act)
                ACT_OSD:   st_d.pix = osd_pix;
                ACT_BLEND: st_d.pix = blend_pix;
                default:   st_d.pix = vid_pix;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mix_pix = st_q.pix;

    // R2: outside the window or with the OSD off, the video pixel passes through
    a_r2_outside_video: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win || !osd_en) |=> (mix_pix == $past(vid_pix)));
    // R8: a hidden OSD yields the video pixel
    a_r8_hidden_video: assert property (@(posedge clk) disable iff (!rst_n)
        hidden |=> (mix_pix == $past(vid_pix)));
    // R6: a reserved action code behaves as video
    a_r6_reserved_is_video: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_RSVD) |=> (mix_pix == $past(vid_pix)));
endmodule

// File: tb/osd_overlay_mixer_tb.sv
module osd_overlay_mixer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] vid_pix = '0, osd_pix = '0, key_color = '0, key_mask = '0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic        vsync = 1'b0, osd_en = 1'b0, key_en = 1'b0, blink_en = 1'b0;
    logic [31:0] ovl_ctrl = '0, win_start = '0, win_end = '0;
    logic [23:0] mix_pix;

    always #2.5 clk = ~clk;

    osd_overlay_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .vid_pix(vid_pix), .osd_pix(osd_pix),
        .pix_x(pix_x), .pix_y(pix_y), .vsync(vsync), .osd_en(osd_en),
        .key_en(key_en), .blink_en(blink_en), .ovl_ctrl(ovl_ctrl),
        .key_color(key_color), .key_mask(key_mask), .win_start(win_start),
        .win_end(win_end), .mix_pix(mix_pix)
    );

    int          n_vec = 0, n_bad = 0;
    logic [23:0] exp_q[$];
    string       tag_q[$];
    int          m_cnt = 0;
    bit          m_hid = 0;
    bit          done = 0;

    function automatic logic [23:0] blend(logic [23:0] v, logic [23:0] o, int w);
        logic [23:0] r;
        for (int c = 0; c < 3; c++)
            r[c*8 +: 8] = 8'((int'(v[c*8 +: 8]) * w + int'(o[c*8 +: 8]) * (15 - w)) / 15);
        return r;
    endfunction

    function automatic logic [23:0] model(logic [23:0] v, logic [23:0] o, int x, int y);
        int  xs, ys, xe, ye, a;
        bit  inw, m;
        xs = int'(win_start[15:0]); ys = int'(win_start[31:16]);
        xe = int'(win_end[15:0]);   ye = int'(win_end[31:16]);
        inw = (x + 1 >= xs) && (x + 1 <= xe) && (y + 1 >= ys) && (y + 1 <= ye);
        if (!osd_en || !inw || m_hid) return v;
        m = key_en && (((o ^ key_color) & key_mask) == 24'h0);
        a = m ? int'(ovl_ctrl[3:2]) : int'(ovl_ctrl[1:0]);
        if (a == 1) return o;
        if (a == 2) return blend(v, o, int'(ovl_ctrl[7:4]));
        return v;
    endfunction

    task automatic blink_step(bit vs);
        int per;
        per = int'(ovl_ctrl[23:16]);
        if (!blink_en) begin
            m_cnt = 0; m_hid = 0;
        end else if (vs) begin
            if (m_cnt + 1 >= per) begin m_cnt = 0; m_hid = !m_hid; end
            else m_cnt = m_cnt + 1;
        end
    endtask

    // driver: one pixel per call, expectation pushed to the scoreboard
    task automatic drv(logic [23:0] v, logic [23:0] o, int x, int y, bit vs, string tag);
        @(negedge clk);
        vid_pix = v; osd_pix = o; pix_x = 16'(x); pix_y = 16'(y); vsync = vs;
        exp_q.push_back(model(v, o, x, y));
        tag_q.push_back(tag);
        blink_step(vs);
        @(posedge clk); #1;
    endtask

    task automatic idle(bit vs);
        @(negedge clk);
        vsync = vs;
        blink_step(vs);
        @(posedge clk); #1;
    endtask

    // monitor: compares one registered result per pushed item
    initial begin
        forever begin
            @(posedge clk); #1;
            if (exp_q.size() > 0) begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (mix_pix !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %06h expected %06h", t, mix_pix, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    localparam logic [23:0] V = 24'hFF8010, O = 24'h0000F0;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (mix_pix !== 24'h0) begin n_bad++; $display("FAIL R1 in reset: got %06h expected 000000", mix_pix); end
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        n_vec++;
        if (mix_pix !== 24'h0) begin n_bad++; $display("FAIL R1 after reset: got %06h expected 000000", mix_pix); end

        // window x0=10 y0=20 width 5 height 3
        win_start = {16'd21, 16'd11};
        win_end   = {16'd23, 16'd15};
        key_mask  = 24'hFFFFFF;
        ovl_ctrl  = 32'h0000_0001;          // no-match -> OSD, match -> video
        drv(V, O, 12, 21, 0, "R2 osd disabled");
        osd_en = 1'b1;
        drv(V, O, 9, 21, 0, "R3 left of window");
        drv(V, O, 10, 21, 0, "R3 first column");
        drv(V, O, 14, 21, 0, "R3 last column");
        drv(V, O, 15, 21, 0, "R3 right of window");
        drv(V, O, 12, 19, 0, "R3 above window");
        drv(V, O, 12, 20, 0, "R3 first row");
        drv(V, O, 12, 22, 0, "R3 last row");
        drv(V, O, 12, 23, 0, "R3 below window");

        // keying
        key_en = 1'b1; key_color = 24'h123456;
        drv(V, 24'h123456, 12, 21, 0, "R4 exact key match");
        drv(V, 24'h123457, 12, 21, 0, "R4 one bit differs");
        key_mask = 24'hFF0000;
        drv(V, 24'h12FFFF, 12, 21, 0, "R4 masked bits ignored");
        drv(V, 24'h13FFFF, 12, 21, 0, "R4 unmasked bit differs");
        key_en = 1'b0; key_mask = 24'hFFFFFF;
        drv(V, 24'h123456, 12, 21, 0, "R5 key off takes no-match");

        // action codes
        key_en = 1'b1;
        ovl_ctrl = 32'h0000_0004;           // match -> OSD, no-match -> video
        drv(V, 24'h123456, 12, 21, 0, "R6 match action OSD");
        drv(V, 24'h654321, 12, 21, 0, "R6 no-match action video");
        ovl_ctrl = 32'h0000_000F;
        drv(V, 24'h123456, 12, 21, 0, "R6 reserved code match");
        drv(V, 24'h000001, 12, 21, 0, "R6 reserved code no-match");

        // blend
        key_en = 1'b0;
        ovl_ctrl = 32'h0000_0052;
        drv(V, O, 12, 21, 0, "R7 weight 5");
        if (model(V, O, 12, 21) !== 24'h552AA5) begin
            n_bad++; $display("FAIL R7 model: got %06h expected 552aa5", model(V, O, 12, 21));
        end
        ovl_ctrl = 32'h0000_00F2;
        drv(V, O, 12, 21, 0, "R7 weight 15");
        ovl_ctrl = 32'h0000_0002;
        drv(V, O, 12, 21, 0, "R7 weight 0");

        // vsync without blink
        ovl_ctrl = 32'h0001_0001;
        for (int i = 0; i < 3; i++) drv(V, O, 12, 21, 1, "R10 vsync with blink off");

        // blink period 3
        ovl_ctrl = 32'h0003_0001;
        blink_en = 1'b1;
        idle(0);
        for (int i = 0; i < 8; i++) drv(V, O, 12, 21, 1, "R8 blink period 3");
        drv(V, O, 12, 21, 0, "R8 between pulses");

        // disable part way, re-enable restarts
        idle(1);
        blink_en = 1'b0;
        drv(V, O, 12, 21, 0, "R9 blink disabled shows OSD");
        blink_en = 1'b1;
        for (int i = 0; i < 4; i++) drv(V, O, 12, 21, 1, "R9 restart after enable");

        // period 0 behaves as 1
        blink_en = 1'b0; idle(0);
        ovl_ctrl = 32'h0000_0001;
        blink_en = 1'b1;
        for (int i = 0; i < 4; i++) drv(V, O, 12, 21, 1, "R8 period zero");
        drv(V, O, 12, 21, 0, "R8 period zero settled");

        repeat (3) idle(0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule